// File: doc/BRIEF.md
# PHY Test-Port Serial Master

This block drives the byte-wide test and control port of a display PHY on its own. A client asks for a register write (address plus data) or a register read (address only) on a single-cycle request port. The block then plays out a fixed series of strobe and bus changes on the PHY's test clock, test enable, test clear and test input bus. It samples the PHY's test output bus at the right point and reports completion with a one-cycle done pulse. The pulse carries the read result, or the monitor value in the case of a write.

Every individual change on the PHY side is followed by a programmable settle time, counted in system clock cycles. The PHY therefore sees each level held for a fixed minimum, whatever the system clock rate. A register address is shifted in when test clock falls while test enable is high. A data byte is shifted in when test clock rises while test enable is low. A read first shifts in the address and takes the PHY's output as the result. It then writes that same byte back so that the register is left unchanged. An address above the highest valid register ends at once with an error flag and no PHY activity. A request that arrives while a sequence is running is dropped.

Top module: `ptif_master`

## Requirements
- R1: During and after reset, `tst_clk`, `tst_en`, `tst_clr`, `tst_din`, `busy`, `done`, `err` and `rdata` are all zero.
- R2: An accepted request with a valid address raises `busy` from the cycle after acceptance. `busy` stays high for exactly 9*(SETTLE_CYC+1) cycles, and `done` pulses for one cycle as `busy` falls. `tst_clr` is held low for the whole sequence.
- R3: The code phase raises `tst_clk`, puts the address on `tst_din`, raises `tst_en`, lowers `tst_clk` (the PHY latches the address on this falling edge with `tst_en` high), then lowers `tst_en`. `tst_en` only rises while `tst_clk` is high and only falls while `tst_clk` is low.
- R4: The data phase lowers `tst_clk`, puts the data byte on `tst_din`, then raises `tst_clk` (the PHY latches the data on this rising edge with `tst_en` low). `tst_clk` is left high and `tst_en` low when `done` pulses.
- R5: In any one cycle, at most one of the four PHY-side groups (`tst_clk`, `tst_en`, `tst_clr`, the `tst_din` bus) changes. Two changes are always at least SETTLE_CYC+1 cycles apart. The data latch edge comes exactly 4*(SETTLE_CYC+1) cycles after the address latch edge.
- R6: A read (`req_write`=0) returns on `rdata` the value of `tst_dout` sampled after the code phase. That same value is written back as the data byte, so the register keeps its contents.
- R7: For a write (`req_write`=1), `rdata` at `done` holds `tst_dout` as sampled at completion.
- R8: An address above MAX_ADDR (default 0x97) is answered in the cycle after the request with `done`=1 and `err`=1. `busy` never rises and no PHY-side signal changes. Address 0x97 itself is accepted normally.
- R9: A request presented while `busy` is high is ignored and causes no PHY-side transaction.
- R10: `done` for an accepted valid-address request has `err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | PHY register address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Sequence in progress; requests are dropped |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Valid with done: address out of range |
| rdata | output | 8 | Read result or write monitor value, valid with done |
| tst_clk | output | 1 | PHY test clock |
| tst_clr | output | 1 | PHY test clear |
| tst_en | output | 1 | PHY test enable |
| tst_din | output | 8 | PHY test input bus |
| tst_dout | input | 8 | PHY test output bus |

## Verification
The bound checker watches every cycle for the following: the single-change rule, the minimum settle gap between PHY-side changes, the pairing of `tst_en` edges with the level of `tst_clk`, the quiet PHY side on an out-of-range request, and `done` coinciding with the fall of `busy`. Some behaviour shows only against a model of the PHY, and the bench scenarios cover it. They check that the right address and data actually latch, that a read returns and writes back the register value, that the write monitor value is correct, and the exact length of a sequence. They also check that a request made during a busy sequence leaves the PHY untouched, and that the boundary address 0x97 passes while 0x98 and 0xFF fail.

// File: rtl/ptif_pkg.sv
package ptif_pkg;

    localparam int unsigned AW = 8;
    localparam int unsigned DW = 8;

    // Ordered PHY-side steps; the order is the protocol.
    typedef enum logic [3:0] {
        STP_CLR_LO    = 4'd0,
        STP_CLK_UP    = 4'd1,
        STP_CODE_BUS  = 4'd2,
        STP_EN_UP     = 4'd3,
        STP_CLK_DOWN  = 4'd4,
        STP_EN_DOWN   = 4'd5,
        STP_CLK_PREP  = 4'd6,
        STP_DATA_BUS  = 4'd7,
        STP_CLK_LATCH = 4'd8
    } step_e;

    localparam int unsigned NUM_STEPS = 9;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic          clk;
        logic          en;
        logic          clr;
        logic [DW-1:0] din;
    } pins_t;

    typedef struct packed {
        logic          write;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } req_t;

    // New PHY-side levels after performing one step.
    function automatic pins_t apply_step(step_e s, pins_t cur,
                                         logic [AW-1:0] code,
                                         logic [DW-1:0] data);
        pins_t nxt;
        nxt = cur;
        case (s)
            STP_CLR_LO:    nxt.clr = 1'b0;
            STP_CLK_UP:    nxt.clk = 1'b1;
            STP_CODE_BUS:  nxt.din = DW'(code);
            STP_EN_UP:     nxt.en  = 1'b1;
            STP_CLK_DOWN:  nxt.clk = 1'b0;
            STP_EN_DOWN:   nxt.en  = 1'b0;
            STP_CLK_PREP:  nxt.clk = 1'b0;
            STP_DATA_BUS:  nxt.din = data;
            STP_CLK_LATCH: nxt.clk = 1'b1;
            default:       nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/ptif_range_chk.sv
module ptif_range_chk #(
    parameter int unsigned AW       = 8,
    parameter int unsigned MAX_ADDR = 32'h97
) (
    input  logic [AW-1:0] addr,
    output logic          ok
);
    localparam logic [AW-1:0] LIMIT = AW'(MAX_ADDR);

    always_comb begin
        ok = (addr <= LIMIT);
    end
endmodule

// File: rtl/ptif_settle.sv
module ptif_settle #(
    parameter int unsigned SETTLE_CYC = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int unsigned CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] RELOAD = CW'(SETTLE_CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= RELOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    always_comb begin
        expired = (cnt_q == '0);
    end
endmodule

// File: rtl/ptif_seq.sv
module ptif_seq
    import ptif_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  req_t          req,
    input  logic          addr_ok,
    input  logic          expired,
    input  logic [DW-1:0] phy_out,
    output logic          load,
    output pins_t         pins,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [DW-1:0] rdata
);
    seq_state_e    state_q;
    step_e         step_q;
    step_e         step_nxt;
    req_t          hold_q;
    pins_t         pins_q;
    logic [DW-1:0] cap_q;
    logic [DW-1:0] data_sel;
    logic          accept;
    logic          advance;
    logic          last_step;

    always_comb begin
        accept    = (state_q == SQ_IDLE) && req_valid;
        last_step = (step_q == STP_CLK_LATCH);
        advance   = (state_q == SQ_RUN) && expired && !last_step;
        load      = (accept && addr_ok) || advance;
        step_nxt  = step_e'(4'(step_q) + 4'd1);
        data_sel  = hold_q.write ? hold_q.wdata : cap_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            step_q  <= STP_CLR_LO;
            hold_q  <= '0;
            pins_q  <= '0;
            cap_q   <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
            err     <= 1'b0;
            rdata   <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (accept) begin
                        if (!addr_ok) begin
                            done <= 1'b1;
                            err  <= 1'b1;
                        end else begin
                            state_q <= SQ_RUN;
                            busy    <= 1'b1;
                            hold_q  <= req;
                            step_q  <= STP_CLR_LO;
                            pins_q  <= apply_step(STP_CLR_LO, pins_q, req.addr, req.wdata);
                        end
                    end
                end
                SQ_RUN: begin
                    if (expired) begin
                        if (last_step) begin
                            state_q <= SQ_IDLE;
                            busy    <= 1'b0;
                            done    <= 1'b1;
                            rdata   <= hold_q.write ? phy_out : cap_q;
                        end else begin
                            step_q <= step_nxt;
                            pins_q <= apply_step(step_nxt, pins_q, hold_q.addr, data_sel);
                            if (step_nxt == STP_CLK_PREP && !hold_q.write) begin
                                cap_q <= phy_out;
                            end
                        end
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        pins = pins_q;
    end
endmodule

// File: rtl/ptif_master.sv
module ptif_master
    import ptif_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 100,
    parameter int unsigned MAX_ADDR   = 32'h97
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [DW-1:0] rdata,
    output logic          tst_clk,
    output logic          tst_clr,
    output logic          tst_en,
    output logic [DW-1:0] tst_din,
    input  logic [DW-1:0] tst_dout
);
    req_t  req;
    pins_t pins;
    logic  addr_ok;
    logic  load;
    logic  expired;

    always_comb begin
        req.write = req_write;
        req.addr  = req_addr;
        req.wdata = req_wdata;
    end

    ptif_range_chk #(
        .AW       (AW),
        .MAX_ADDR (MAX_ADDR)
    ) u_range (
        .addr (req_addr),
        .ok   (addr_ok)
    );

    ptif_settle #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_settle (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .expired (expired)
    );

    ptif_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req       (req),
        .addr_ok   (addr_ok),
        .expired   (expired),
        .phy_out   (tst_dout),
        .load      (load),
        .pins      (pins),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .rdata     (rdata)
    );

    always_comb begin
        tst_clk = pins.clk;
        tst_clr = pins.clr;
        tst_en  = pins.en;
        tst_din = pins.din;
    end
endmodule

// File: rtl/ptif_master_chk.sv
module ptif_master_chk #(
    parameter int unsigned SETTLE_CYC = 100
) (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic       tst_clk,
    input logic       tst_clr,
    input logic       tst_en,
    input logic [7:0] tst_din
);
    localparam int unsigned GW = (SETTLE_CYC < 2) ? 2 : $clog2(SETTLE_CYC + 1) + 1;
    localparam logic [GW-1:0] GAP_MIN = GW'(SETTLE_CYC);

    logic [10:0]   prev_q;
    logic [10:0]   now_v;
    logic          chg;
    logic          seen_q;
    logic [GW-1:0] since_q;

    always_comb begin
        now_v = {tst_clk, tst_en, tst_clr, tst_din};
        chg   = (now_v != prev_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            seen_q  <= 1'b0;
            since_q <= '0;
        end else begin
            prev_q <= now_v;
            if (chg) begin
                seen_q  <= 1'b1;
                since_q <= '0;
            end else if (since_q < GAP_MIN) begin
                since_q <= since_q + GW'(1);
            end
        end
    end

    // R5: never two PHY-side groups changing together
    p_one_group_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!$stable(tst_clk), !$stable(tst_en), !$stable(tst_clr), !$stable(tst_din)}));

    // R5: settle gap between consecutive changes
    p_settle_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (chg && seen_q) |-> (since_q >= GAP_MIN));

    // R3: enable rises only with test clock high
    p_en_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(tst_en) |-> tst_clk);

    // R3: enable falls only with test clock low
    p_en_fall_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(tst_en) |-> !tst_clk);

    // R3: test clock only falls while enable is high (address latch)
    p_clk_fall_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(tst_clk) |-> tst_en);

    // R8: out-of-range answer leaves the PHY side untouched
    p_err_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (!busy && $stable(tst_clk) && $stable(tst_en) && $stable(tst_din)));

    // R2 / R10: end of busy is a clean done
    p_busy_done_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done && !err));

    // R2: clear strobe stays low while a sequence runs
    p_clr_low_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> !tst_clr);
endmodule

bind ptif_master ptif_master_chk #(
    .SETTLE_CYC (SETTLE_CYC)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .tst_clk (tst_clk),
    .tst_clr (tst_clr),
    .tst_en  (tst_en),
    .tst_din (tst_din)
);

// File: tb/ptif_master_tb.sv
module ptif_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 3;
    localparam int SEQ_LEN    = 9 * (SETTLE + 1);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [7:0] req_addr  = '0;
    logic [7:0] req_wdata = '0;
    logic       busy, done, err;
    logic [7:0] rdata;
    logic       tst_clk, tst_clr, tst_en;
    logic [7:0] tst_din;
    logic [7:0] tst_dout;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(negedge clk) cyc <= cyc + 1;

    ptif_master #(.SETTLE_CYC(SETTLE)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .err(err), .rdata(rdata), .tst_clk(tst_clk), .tst_clr(tst_clr),
        .tst_en(tst_en), .tst_din(tst_din), .tst_dout(tst_dout)
    );

    // PHY register model driven only by the port strobes
    logic [7:0]   phy_mem [256];
    logic [255:0] phy_wr;
    logic [7:0]   phy_code;
    int code_latches = 0;
    int data_latches = 0;
    int t_code = 0;
    int t_data = 0;

    always @(negedge tst_clk or posedge rst) begin
        if (rst) phy_code <= 8'h00;
        else if (tst_en) begin
            phy_code <= tst_din;
            code_latches++;
            t_code = cyc;
        end
    end

    always @(posedge tst_clk or posedge rst) begin
        if (rst) phy_wr <= '0;
        else if (!tst_en) begin
            phy_mem[phy_code] <= tst_din;
            phy_wr[phy_code]  <= 1'b1;
            data_latches++;
            t_data = cyc;
        end
    end

    assign tst_dout = phy_wr[phy_code] ? phy_mem[phy_code] : (phy_code ^ 8'h5A);

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_txn(input bit wr, input logic [7:0] a, input logic [7:0] d,
                          input bit poke, output logic [7:0] rd,
                          output bit er, output int nbusy);
        int guard;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        nbusy = 0;
        guard = 0;
        while (!done) begin
            if (busy) nbusy++;
            if (poke && nbusy == 5) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h21; req_wdata = 8'h77;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            guard++;
            if (guard > 1000) begin
                chk(1'b0, "watchdog", guard, 0);
                summary();
            end
        end
        req_valid = 1'b0;
        rd = rdata;
        er = err;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk({busy, done, err, tst_clk, tst_en, tst_clr} == 6'b0, "R1 strobes/status",
            {busy, done, err, tst_clk, tst_en, tst_clr}, 0);
        chk(tst_din == 8'h00 && rdata == 8'h00, "R1 buses", {tst_din, rdata}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !tst_clk, "R1 idle after release", busy, 0);
    endtask

    task automatic t_write();
        logic [7:0] rd; bit er; int nb; int c0, d0;
        do_txn(1'b1, 8'h01, 8'h00, 1'b0, rd, er, nb);   // brings test clock high
        c0 = code_latches; d0 = data_latches;
        do_txn(1'b1, 8'h10, 8'hA5, 1'b0, rd, er, nb);
        chk(nb == SEQ_LEN, "R2 busy length", nb, SEQ_LEN);
        chk(er == 1'b0, "R10 no error", er, 0);
        chk(rd == 8'hA5, "R7 write monitor", rd, 8'hA5);
        chk(phy_mem[8'h10] == 8'hA5 && phy_wr[8'h10], "R4 data latched", phy_mem[8'h10], 8'hA5);
        chk(tst_clk && !tst_en, "R4 end levels", {tst_clk, tst_en}, 2'b10);
        chk(!tst_clr, "R2 clear low", tst_clr, 0);
        chk(phy_code == 8'h10 && code_latches == c0 + 1, "R3 address latch", phy_code, 8'h10);
        chk(data_latches == d0 + 1, "R4 one data latch", data_latches - d0, 1);
        chk(t_data - t_code == 4 * (SETTLE + 1), "R5 latch spacing", t_data - t_code, 4 * (SETTLE + 1));
    endtask

    task automatic t_read();
        logic [7:0] rd; bit er; int nb; int d0;
        do_txn(1'b0, 8'h40, 8'hEE, 1'b0, rd, er, nb);
        chk(rd == (8'h40 ^ 8'h5A), "R6 read default", rd, 8'h40 ^ 8'h5A);
        chk(nb == SEQ_LEN && !er, "R2 read length", nb, SEQ_LEN);
        chk(phy_mem[8'h40] == (8'h40 ^ 8'h5A), "R6 write-back value", phy_mem[8'h40], 8'h40 ^ 8'h5A);
        d0 = data_latches;
        do_txn(1'b1, 8'h33, 8'h3C, 1'b0, rd, er, nb);
        do_txn(1'b0, 8'h33, 8'h00, 1'b0, rd, er, nb);
        chk(rd == 8'h3C, "R6 read after write", rd, 8'h3C);
        chk(phy_mem[8'h33] == 8'h3C && data_latches == d0 + 2, "R6 register kept", phy_mem[8'h33], 8'h3C);
    endtask

    task automatic t_boundary();
        logic [7:0] rd; bit er; int nb;
        do_txn(1'b1, 8'h97, 8'hC3, 1'b0, rd, er, nb);
        chk(!er && nb == SEQ_LEN, "R8 top address accepted", er, 0);
        do_txn(1'b0, 8'h97, 8'h00, 1'b0, rd, er, nb);
        chk(rd == 8'hC3, "R8 top address readback", rd, 8'hC3);
    endtask

    task automatic t_bad_addr(input logic [7:0] a);
        logic [7:0] rd; bit er; int nb; int c0, d0; logic [10:0] lv;
        c0 = code_latches; d0 = data_latches;
        lv = {tst_clk, tst_en, tst_clr, tst_din};
        do_txn(1'b1, a, 8'h55, 1'b0, rd, er, nb);
        chk(er == 1'b1 && nb == 0, "R8 immediate error", {er, 8'(nb)}, 9'h100);
        chk(code_latches == c0 && data_latches == d0, "R8 no latches",
            code_latches - c0 + data_latches - d0, 0);
        chk({tst_clk, tst_en, tst_clr, tst_din} == lv, "R8 pins unchanged",
            {tst_clk, tst_en, tst_clr, tst_din}, lv);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] rd; bit er; int nb; int c0;
        c0 = code_latches;
        do_txn(1'b1, 8'h20, 8'h11, 1'b1, rd, er, nb);
        repeat (2) @(negedge clk);
        chk(code_latches == c0 + 1 && !busy, "R9 single transaction", code_latches - c0, 1);
        do_txn(1'b0, 8'h21, 8'h00, 1'b0, rd, er, nb);
        chk(rd == (8'h21 ^ 8'h5A), "R9 dropped write absent", rd, 8'h21 ^ 8'h5A);
    endtask

    initial begin
        t_reset();
        t_write();
        t_read();
        t_boundary();
        t_bad_addr(8'h98);
        t_bad_addr(8'hFF);
        t_busy_ignore();
        summary();
    end

    initial begin
        repeat (200000) @(negedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        summary();
    end
endmodule